// File: doc/BRIEF.md
# Grouped Event Flag Combiner

This block collects 128 single-cycle event strobes into sticky flag bits held in four groups of 32. Event number n lives in group n/32 at bit n%32. Software reaches the flags through a small synchronous 32-bit register port. It can set bits, clear bits, program two independent masks per group and read back the raw and masked views.

Each group drives one combined output. That output is high while any flag of the group is both set and not disabled by the group's event mask. A second mask per group screens the same flags for the exception path, and all four groups together drive one exception output. The four lowest event numbers carry no external source. Instead, each group's combined output re-enters the flag array as an event on its rising edge. Software can also raise any event by number through an event-assert register.

Top module: `evc_combiner`

## Requirements
- R1: After reset every flag is 0, both masks of every group read 0xFFFFFFFF, `comb_o` and `exc_o` are low and `bus_rdata` is 0.
- R2: A high cycle on `evt_i[n]` for n of 4 or more sets flag bit n%32 of group n/32 at the next clock edge. The flag register of group g is read at byte offset 0x00+4g.
- R3: A write to offset 0x20+4g sets every flag of group g whose data bit is 1. A write to 0x40+4g clears exactly the flags whose data bit is 1. A flag that is set by any source in the same cycle as its clear ends up set.
- R4: The event mask at 0x80+4g and the exception mask at 0xC0+4g are read/write. A mask bit of 1 disables the flag bit at that position and a 0 enables it.
- R5: The masked-flag register at 0xA0+4g reads flags AND NOT event mask, and `comb_o[g]` is high exactly while that value is nonzero.
- R6: The masked-exception register at 0xE0+4g reads flags AND NOT exception mask, and `exc_o` is high exactly while any group's value is nonzero.
- R7: On the edge where `comb_o[g]` is seen newly high, flag bit g of group 0 is set. `evt_i[3:0]` have no effect.
- R8: A write to offset 0x1C0 sets the flag of event number `bus_wdata[6:0]` at that edge, and the higher data bits are ignored.
- R9: Offsets not listed, group indices 4 to 7, the set, clear and event-assert registers, and any address with `bus_addr[1:0]` nonzero all read as 0. Writes to those addresses, and to the flag and masked registers, change nothing.
- R10: `bus_rdata` is loaded on each edge where `bus_rd` is high, with the state before any write of that same edge, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| evt_i | input | 128 | Event strobes, one per event number (bits 3:0 unused) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| comb_o | output | 4 | Combined event output per group |
| exc_o | output | 1 | Exception output |

## Verification
Flags and masks move on the edge that samples an event strobe or a write. The combined and exception outputs follow through logic alone, so they are valid in the same cycle after that edge. Read data comes one edge after the read strobe. Feedback into group 0 lands one edge after a combined output rises, and so shows on a read one cycle later than the event that caused it. The bench drives every input on the falling edge and advances a per-edge model of flags, masks and previous combined values alongside the design. It compares `comb_o` and `exc_o` at each following falling edge, and read data one edge after the strobe.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Byte address width of the register port.
  localparam int unsigned EVC_AW = 9;
  // Address fields: bank selects the register kind, index the group.
  localparam int unsigned EVC_BANK_LSB = 5;
  localparam int unsigned EVC_BANK_W   = 4;
  localparam int unsigned EVC_IDX_LSB  = 2;
  localparam int unsigned EVC_IDX_W    = 3;

  typedef enum logic [EVC_BANK_W-1:0] {
    BK_FLAG   = 4'd0,
    BK_SET    = 4'd1,
    BK_CLR    = 4'd2,
    BK_EMASK  = 4'd4,
    BK_MFLAG  = 4'd5,
    BK_XMASK  = 4'd6,
    BK_XMFLAG = 4'd7,
    BK_ASSERT = 4'd14
  } bank_e;

endpackage

// File: rtl/evc_rst_sync.sv
module evc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/evc_regdec.sv
module evc_regdec
  import evc_pkg::*;
#(
  parameter int unsigned NGRP = 4
) (
  input  logic                  bus_wr,
  input  logic [EVC_AW-1:0]     bus_addr,
  output logic [NGRP-1:0]       set_we,
  output logic [NGRP-1:0]       clr_we,
  output logic [NGRP-1:0]       em_we,
  output logic [NGRP-1:0]       xm_we,
  output logic                  asrt_we,
  output bank_e                 bank,
  output logic [EVC_IDX_W-1:0]  idx,
  output logic                  idx_ok
);

  logic aligned;

  always_comb begin
    bank    = bank_e'(bus_addr[EVC_BANK_LSB +: EVC_BANK_W]);
    idx     = bus_addr[EVC_IDX_LSB +: EVC_IDX_W];
    aligned = (bus_addr[1:0] == 2'b00);
    idx_ok  = aligned && (32'(idx) < NGRP);
    asrt_we = bus_wr && aligned && (bank == BK_ASSERT) && (idx == '0);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_we
    logic sel;
    assign sel       = bus_wr && idx_ok && (32'(idx) == g);
    assign set_we[g] = sel && (bank == BK_SET);
    assign clr_we[g] = sel && (bank == BK_CLR);
    assign em_we[g]  = sel && (bank == BK_EMASK);
    assign xm_we[g]  = sel && (bank == BK_XMASK);
  end

endmodule

// File: rtl/evc_group.sv
module evc_group #(
  parameter int unsigned GW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] evt_i,
  input  logic [GW-1:0] asrt_i,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          em_we,
  input  logic          xm_we,
  input  logic [GW-1:0] wdata,
  output logic [GW-1:0] flag_o,
  output logic [GW-1:0] emask_o,
  output logic [GW-1:0] xmask_o,
  output logic [GW-1:0] mflag_o,
  output logic [GW-1:0] xmflag_o,
  output logic          comb_o,
  output logic          xany_o
);

  logic [GW-1:0] flag_q, flag_d;
  logic [GW-1:0] em_q, em_d;
  logic [GW-1:0] xm_q, xm_d;
  logic [GW-1:0] set_bits, clr_bits;

  // Next state: clears apply first, every set source overrides them.
  always_comb begin
    set_bits = set_we ? wdata : '0;
    clr_bits = clr_we ? wdata : '0;
    flag_d   = (flag_q & ~clr_bits) | set_bits | evt_i | asrt_i;
    em_d     = em_q;
    if (em_we) em_d = wdata;
    xm_d     = xm_q;
    if (xm_we) xm_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      em_q   <= '1;
      xm_q   <= '1;
    end else begin
      flag_q <= flag_d;
      em_q   <= em_d;
      xm_q   <= xm_d;
    end
  end

  assign flag_o   = flag_q;
  assign emask_o  = em_q;
  assign xmask_o  = xm_q;
  assign mflag_o  = flag_q & ~em_q;
  assign xmflag_o = flag_q & ~xm_q;
  assign comb_o   = |mflag_o;
  assign xany_o   = |xmflag_o;

endmodule

// File: rtl/evc_combiner.sv
module evc_combiner
  import evc_pkg::*;
#(
  parameter int unsigned NGRP = 4,
  parameter int unsigned GW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*GW-1:0]   evt_i,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [EVC_AW-1:0]    bus_addr,
  input  logic [GW-1:0]        bus_wdata,
  output logic [GW-1:0]        bus_rdata,
  output logic [NGRP-1:0]      comb_o,
  output logic                 exc_o
);

  localparam int unsigned NEV = NGRP * GW;
  localparam int unsigned EIW = $clog2(NEV);
  localparam int unsigned GIW = (NGRP > 1) ? $clog2(NGRP) : 1;
  // External strobes for the lowest NGRP events are replaced by feedback.
  localparam logic [NEV-1:0] EXT_KEEP = {{(NEV-NGRP){1'b1}}, {NGRP{1'b0}}};

  logic rst_n_s;

  evc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  logic [NGRP-1:0]      set_we, clr_we, em_we, xm_we;
  logic                 asrt_we;
  bank_e                bank;
  logic [EVC_IDX_W-1:0] idx;
  logic                 idx_ok;

  evc_regdec #(.NGRP(NGRP)) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .set_we   (set_we),
    .clr_we   (clr_we),
    .em_we    (em_we),
    .xm_we    (xm_we),
    .asrt_we  (asrt_we),
    .bank     (bank),
    .idx      (idx),
    .idx_ok   (idx_ok)
  );

  // Rising-edge detect of the combined outputs for feedback.
  logic [NGRP-1:0] comb_w, comb_q, comb_d, fb;

  always_comb begin
    comb_d = comb_w;
    fb     = comb_w & ~comb_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) comb_q <= '0;
    else          comb_q <= comb_d;
  end

  logic [NEV-1:0] ev_all, asrt_vec;

  always_comb begin
    ev_all = (evt_i & EXT_KEEP) | {{(NEV-NGRP){1'b0}}, fb};
    asrt_vec = '0;
    if (asrt_we) asrt_vec[bus_wdata[EIW-1:0]] = 1'b1;
  end

  logic [GW-1:0]   flag_w  [NGRP];
  logic [GW-1:0]   em_w    [NGRP];
  logic [GW-1:0]   xm_w    [NGRP];
  logic [GW-1:0]   mf_w    [NGRP];
  logic [GW-1:0]   xmf_w   [NGRP];
  logic [NGRP-1:0] xany_w;
  logic [NEV-1:0]  flag_all;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    evc_group #(.GW(GW)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n_s),
      .evt_i    (ev_all[g*GW +: GW]),
      .asrt_i   (asrt_vec[g*GW +: GW]),
      .set_we   (set_we[g]),
      .clr_we   (clr_we[g]),
      .em_we    (em_we[g]),
      .xm_we    (xm_we[g]),
      .wdata    (bus_wdata),
      .flag_o   (flag_w[g]),
      .emask_o  (em_w[g]),
      .xmask_o  (xm_w[g]),
      .mflag_o  (mf_w[g]),
      .xmflag_o (xmf_w[g]),
      .comb_o   (comb_w[g]),
      .xany_o   (xany_w[g])
    );
    assign flag_all[g*GW +: GW] = flag_w[g];
  end

  // Read path.
  logic [GW-1:0]  rd_d, rdata_q, rdata_d;
  logic [GIW-1:0] gsel;

  always_comb begin
    gsel = idx[GIW-1:0];
    rd_d = '0;
    if (idx_ok) begin
      case (bank)
        BK_FLAG:   rd_d = flag_w[gsel];
        BK_EMASK:  rd_d = em_w[gsel];
        BK_MFLAG:  rd_d = mf_w[gsel];
        BK_XMASK:  rd_d = xm_w[gsel];
        BK_XMFLAG: rd_d = xmf_w[gsel];
        default:   rd_d = '0;
      endcase
    end
    rdata_d = rdata_q;
    if (bus_rd) rdata_d = rd_d;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign comb_o    = comb_w;
  assign exc_o     = |xany_w;

endmodule

// File: rtl/evc_combiner_chk.sv
module evc_combiner_chk #(
  parameter int unsigned NGRP = 4,
  parameter int unsigned GW   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NGRP*GW-1:0]  evt_i,
  input logic [NGRP*GW-1:0]  flag_q,
  input logic [NGRP-1:0]     comb_o,
  input logic                exc_o,
  input logic                bus_rd,
  input logic [GW-1:0]       bus_rdata
);

  localparam int unsigned NEV = NGRP * GW;
  localparam logic [NEV-1:0] EXT_KEEP = {{(NEV-NGRP){1'b1}}, {NGRP{1'b0}}};

  logic [NEV-1:0] evh;
  assign evh = evt_i & EXT_KEEP;

  // R2: an external strobe has its flag set one edge later.
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(evh)) == $past(evh)));

  // R6: the exception output needs some flag set.
  a_r6_exc_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> (flag_q != '0));

  // R10: read data holds while no read strobe is sampled.
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R5: a combined output needs a flag in its own group.
    a_r5_comb_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
      comb_o[g] |-> (flag_q[g*GW +: GW] != '0));
    // R7: a rising combined output lands in group 0 one edge later.
    a_r7_feedback: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(comb_o[g]) |=> flag_q[g]);
  end

endmodule

bind evc_combiner evc_combiner_chk #(.NGRP(NGRP), .GW(GW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .evt_i     (evt_i),
  .flag_q    (flag_all),
  .comb_o    (comb_o),
  .exc_o     (exc_o),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata)
);

// File: tb/evc_combiner_bench.sv
module evc_combiner_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] evt;
  logic         wr, rd;
  logic [8:0]   addr;
  logic [31:0]  wdata;
  logic [31:0]  rdata;
  logic [3:0]   comb;
  logic         exc;

  always #(CLK_PERIOD/2) clk = ~clk;

  evc_combiner u_evc_combiner (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .comb_o    (comb),
    .exc_o     (exc)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_flag [4];
  logic [31:0] m_em   [4];
  logic [31:0] m_xm   [4];
  logic [3:0]  m_cq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] ra(input int bank, input int g);
    return 9'((bank << 5) | (g << 2));
  endfunction

  function automatic logic [31:0] mread(input logic [8:0] a);
    int k, g;
    k = int'(a[8:5]);
    g = int'(a[4:2]);
    if (a[1:0] != 2'b00 || g >= 4) return 32'h0;
    case (k)
      0: return m_flag[g];
      4: return m_em[g];
      5: return m_flag[g] & ~m_em[g];
      6: return m_xm[g];
      7: return m_flag[g] & ~m_xm[g];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] mcomb();
    logic [3:0] c;
    for (int g = 0; g < 4; g++) c[g] = |(m_flag[g] & ~m_em[g]);
    return c;
  endfunction

  function automatic logic mexc();
    logic x = 1'b0;
    for (int g = 0; g < 4; g++) x = x | (|(m_flag[g] & ~m_xm[g]));
    return x;
  endfunction

  // One clock: model advances per the requirements, outputs checked after.
  task automatic cyc(input string tag);
    logic [3:0]  mc;
    logic [31:0] exp_rd;
    logic        rd_was;
    logic [31:0] nf [4];
    logic [31:0] ne [4];
    logic [31:0] nx [4];
    int k, gi, e;
    logic ok;
    mc     = mcomb();
    exp_rd = mread(addr);
    rd_was = rd;
    k  = int'(addr[8:5]);
    gi = int'(addr[4:2]);
    ok = wr && (addr[1:0] == 2'b00);
    for (int g = 0; g < 4; g++) begin
      logic [31:0] ev, s, c;
      ev = evt[g*32 +: 32];
      if (g == 0) ev[3:0] = mc & ~m_cq;
      s = 32'h0;
      c = 32'h0;
      ne[g] = m_em[g];
      nx[g] = m_xm[g];
      if (ok && gi == g) begin
        if (k == 1) s = wdata;
        if (k == 2) c = wdata;
        if (k == 4) ne[g] = wdata;
        if (k == 6) nx[g] = wdata;
      end
      if (ok && k == 14 && gi == 0) begin
        e = int'(wdata[6:0]);
        if (e / 32 == g) ev[e % 32] = 1'b1;
      end
      nf[g] = (m_flag[g] & ~c) | s | ev;
    end
    @(posedge clk);
    for (int g = 0; g < 4; g++) begin
      m_flag[g] = nf[g];
      m_em[g]   = ne[g];
      m_xm[g]   = nx[g];
    end
    m_cq = mc;
    @(negedge clk);
    chk("R5 comb_o", 32'(comb), 32'(mcomb()));
    chk("R6 exc_o", 32'(exc), 32'(mexc()));
    if (rd_was) chk(tag, rdata, exp_rd);
    evt = '0;
    wr  = 1'b0;
    rd  = 1'b0;
  endtask

  task automatic wreg(input logic [8:0] a, input logic [31:0] d, input string tag);
    wr = 1'b1; addr = a; wdata = d;
    cyc(tag);
  endtask

  task automatic rreg(input logic [8:0] a, input string tag);
    rd = 1'b1; addr = a;
    cyc(tag);
  endtask

  task automatic pulse(input int n);
    evt[n] = 1'b1;
    cyc("R2 pulse");
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0;
    evt = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    for (int g = 0; g < 4; g++) begin
      m_flag[g] = 32'h0; m_em[g] = 32'hFFFF_FFFF; m_xm[g] = 32'hFFFF_FFFF;
    end
    m_cq = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset comb_o", 32'(comb), 32'h0);
    chk("R1 reset exc_o", 32'(exc), 32'h0);
    chk("R1 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) cyc("R1 idle");

    // R1: reset values of every register.
    for (int g = 0; g < 4; g++) begin
      rreg(ra(0, g), "R1 flag reset");
      rreg(ra(4, g), "R1 emask reset");
      rreg(ra(6, g), "R1 xmask reset");
    end

    // R2, R3: every external event while masked, then single-bit clear.
    for (int n = 4; n < 128; n++) begin
      pulse(n);
      rreg(ra(0, n / 32), "R2 flag set");
      rreg(ra(5, n / 32), "R5 masked flag");
      wreg(ra(2, n / 32), 32'h1 << (n % 32), "R3 clear");
      rreg(ra(0, n / 32), "R3 flag cleared");
    end

    // R7: strobes on the feedback positions are ignored.
    evt[3:0] = 4'hF;
    cyc("R7 ignored");
    rreg(ra(0, 0), "R7 evt_i[3:0] ignored");
    chk("R7 evt_i[3:0] ignored direct", rdata, 32'h0);

    // R4, R5, R7: unmask and sweep again; feedback to group 0 masked.
    wreg(ra(4, 0), 32'h0000_000F, "R4 emask write");
    for (int g = 1; g < 4; g++) wreg(ra(4, g), 32'h0, "R4 emask write");
    rreg(ra(4, 0), "R4 emask read");
    for (int n = 4; n < 128; n++) begin
      pulse(n);
      rreg(ra(5, n / 32), "R5 masked flag open");
      cyc("R7 settle");
      rreg(ra(0, 0), "R7 feedback flag");
      if (n / 32 == 0) wreg(ra(2, 0), (32'h1 << (n % 32)) | 32'hF, "R3 clear");
      else begin
        wreg(ra(2, n / 32), 32'h1 << (n % 32), "R3 clear");
        wreg(ra(2, 0), 32'hF, "R3 clear fb");
      end
    end
    rreg(ra(0, 0), "R7 group0 empty");
    for (int g = 0; g < 4; g++) wreg(ra(4, g), 32'hFFFF_FFFF, "R4 emask restore");

    // R6: exception masks with several patterns.
    for (int g = 0; g < 4; g++) begin
      wreg(ra(6, g), 32'h0F0F_0F0F, "R4 xmask write");
      rreg(ra(6, g), "R4 xmask read");
      for (int b = 0; b < 32; b += 3) begin
        wreg(ra(1, g), 32'h1 << b, "R3 set");
        rreg(ra(7, g), "R6 masked exception");
        wreg(ra(2, g), 32'hFFFF_FFFF, "R3 clear all");
      end
      wreg(ra(1, g), 32'hA5A5_A5A5, "R3 set");
      rreg(ra(7, g), "R6 masked exception pattern");
      wreg(ra(6, g), 32'h0, "R4 xmask open");
      rreg(ra(7, g), "R6 masked exception open");
      wreg(ra(2, g), 32'hFFFF_FFFF, "R3 clear all");
      wreg(ra(6, g), 32'hFFFF_FFFF, "R4 xmask restore");
    end

    // R3: clear touches only its bit, and set beats clear.
    wreg(ra(1, 2), 32'hFFFF_FFFF, "R3 set all");
    wreg(ra(2, 2), 32'h0001_0000, "R3 clear one");
    rreg(ra(0, 2), "R3 clear only one bit");
    chk("R3 clear only one bit direct", rdata, 32'hFFFE_FFFF);
    wreg(ra(2, 2), 32'hFFFF_FFFF, "R3 clear all");
    for (int n = 4; n < 128; n += 17) begin
      evt[n] = 1'b1;
      wreg(ra(2, n / 32), 32'h1 << (n % 32), "R3 collision");
      rreg(ra(0, n / 32), "R3 set wins");
      wreg(ra(2, n / 32), 32'hFFFF_FFFF, "R3 clear all");
    end

    // R8: event assert by number, high data bits are noise.
    for (int n = 0; n < 128; n++) begin
      wreg(9'h1C0, 32'hFFFF_FF80 | 32'(n), "R8 assert");
      rreg(ra(0, n / 32), "R8 assert flag");
      wreg(ra(2, n / 32), 32'hFFFF_FFFF, "R3 clear all");
    end
    rreg(9'h1C0, "R9 assert reads zero");

    // R9: reserved, read-only and misaligned accesses.
    wreg(ra(4, 0), 32'h1234_5678, "R4 emask write");
    wreg(ra(0, 1), 32'hFFFF_FFFF, "R9 flag ro");
    wreg(ra(5, 1), 32'hFFFF_FFFF, "R9 mflag ro");
    wreg(ra(7, 1), 32'hFFFF_FFFF, "R9 xmflag ro");
    wreg(ra(3, 0), 32'hFFFF_FFFF, "R9 reserved");
    wreg(ra(4, 4), 32'h0, "R9 group4");
    wreg(ra(8, 0), 32'hFFFF_FFFF, "R9 unlisted");
    wreg(9'h1C4, 32'h0000_0040, "R9 assert alias");
    wreg(9'h082, 32'h0, "R9 misaligned");
    wreg(9'h022, 32'hFFFF_FFFF, "R9 misaligned set");
    rreg(ra(4, 0), "R9 emask unchanged");
    chk("R9 emask unchanged direct", rdata, 32'h1234_5678);
    for (int g = 0; g < 4; g++) rreg(ra(0, g), "R9 flags unchanged");
    rreg(ra(1, 0), "R9 set reads zero");
    rreg(ra(2, 0), "R9 clear reads zero");
    rreg(ra(3, 0), "R9 reserved reads zero");
    rreg(ra(4, 5), "R9 group5 reads zero");
    rreg(ra(8, 0), "R9 unlisted reads zero");
    rreg(9'h081, "R9 misaligned reads zero");

    // R10: read sees pre-write state, then holds.
    wr = 1'b1; rd = 1'b1; addr = ra(4, 1); wdata = 32'hCAFE_0000;
    cyc("R10 read before write");
    held = rdata;
    chk("R10 old value", held, 32'hFFFF_FFFF);
    wreg(ra(4, 1), 32'h0000_BEEF, "R10 write");
    wreg(ra(1, 3), 32'h0000_0010, "R10 write");
    cyc("R10 idle");
    chk("R10 rdata held", rdata, held);
    rreg(ra(4, 1), "R10 new value");

    finish_run();
  end

endmodule